// File: doc/BRIEF.md
# Banked-Register SPI Command Slave

This block is an SPI mode-0 target running in a single system clock domain. It oversamples the serial clock, chip select and data-in through two-flop synchronizers, assembles bytes, and decodes a byte-oriented command set. The command set works on a control-register file of four banks. Each command is carried in one chip-select frame. The first byte is a header: bits 7:5 hold an opcode and bits 4:0 hold a register address. Control registers can be read, written, bit-set and bit-cleared. A byte-wide memory port gives streaming access to an external buffer through auto-incrementing pointers. A one-byte command returns the bank selection to zero.

Within each bank, addresses 0x00 to 0x1A are private to that bank. Addresses 0x1B to 0x1F are one set of shared registers that every bank sees. Bits 1:0 of shared register 0x1F select the active bank. Ordinary write, set and clear commands aimed at 0x1F therefore switch banks. A group of registers is read through a delayed path, and for these registers the data follows one dummy byte.

Timing assumption: the serial clock stays high for at least 4 system clock cycles and low for at least 4 system clock cycles.

Top module: `spi_bank_regs`

## Requirements
- R1: A command is made of the complete bytes received between a falling and a rising edge of `cs_n`. Bits are sampled on rising `sclk` and taken MSB first. Header bits 7:5 are the opcode and bits 4:0 the address. `miso` changes after falling `sclk`, sends MSB first, and gives 0x00 during the header byte. `miso` is 0 while `cs_n` is high.
- R2: Opcode 010 (write) in a frame of exactly two complete bytes stores the second byte into the addressed register of the active bank.
- R3: Opcode 000 (read) on a register that is not in the delayed class returns the register value on `miso` during the second byte.
- R4: The delayed class is bank 2 addresses 0x00–0x1A, plus bank 3 addresses 0x00–0x05 and 0x0A. A read of one of these sends 0x00 during the second byte and the value during the third byte.
- R5: The active bank is bits 1:0 of register 0x1F, with bit 1 as the MSB. Private addresses 0x00–0x1A hold separate values in each bank. Addresses 0x1B–0x1F are the same registers in every bank. The bank changes only when a frame ends.
- R6: Opcode 100 ORs the data byte into the register, and opcode 101 clears the register bits set in the data byte. Both need exactly two complete bytes. When aimed at 0x1F they switch the bank.
- R7: Set and clear commands aimed at a delayed-class register leave it unchanged.
- R8: Opcode 111 in a frame of exactly one byte clears bits 1:0 of 0x1F and keeps its other bits. A frame with opcode 111 and two bytes has no effect.
- R9: A control command with the wrong byte count or a trailing partial byte has no effect, and neither does opcode 110.
- R10: Header 0x7A is a buffer write. Each following complete byte pulses `buf_we` for one cycle, with `buf_addr` set to the write pointer {bank 0 reg 0x03[4:0], bank 0 reg 0x02}. The pointer then advances by one, and the new value can be read back.
- R11: Header 0x3A is a buffer read. Data byte k (k = 1, 2, …) carries memory[P+k-1], where P is the read pointer {bank 0 reg 0x01[4:0], bank 0 reg 0x00}. After N data bytes the pointer equals P+N. Each `buf_re` pulse lasts one cycle, and `buf_rdata` is expected on the cycle after it.
- R12: Headers that carry opcode 001 or 011 but differ from 0x3A or 0x7A cause no `buf_we` or `buf_re`.
- R13: Buffer pointers wrap from 0x1FFF to 0x0000.
- R14: After reset every register is 0x00 (so bank 0 is active), `miso` is 0 and no buffer strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select, frames one command |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| buf_addr | output | PTR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | Buffer write strobe |
| buf_re | output | 1 | Buffer read strobe |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after `buf_re` |

## Verification
The delayed read path and the pointer wrap are the hardest cases to reach from the ports. The delayed class exists only in banks 2 and 3, so the stimulus first switches banks with writes, sets and clears to 0x1F, then compares two-byte and three-byte reads of neighbouring addresses. To reach the 13-bit wrap, the bench loads the pointer registers to 0x1FFF with plain control writes, then streams buffer bytes across the boundary and reads the pointer back. Frames that end early are cut off after a few bits of a byte, which checks that partial bytes never commit.

// File: rtl/spi_bank_regs.sv
module spi_bank_regs #(
  parameter int PTR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic [PTR_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  output logic             buf_we,
  output logic             buf_re,
  input  logic [7:0]       buf_rdata
);
  localparam int NBANK = 4;
  localparam int NPRIV = 27;
  localparam int NSH   = 5;
  localparam int HI_W  = PTR_W - 8;
  localparam logic [4:0] SH_LO = 5'(NPRIV);
  localparam logic [2:0] OP_RD  = 3'b000;
  localparam logic [2:0] OP_WR  = 3'b010;
  localparam logic [2:0] OP_SET = 3'b100;
  localparam logic [2:0] OP_CLR = 3'b101;
  localparam logic [2:0] OP_RST = 3'b111;
  localparam logic [7:0] HDR_BRD = 8'h3A;
  localparam logic [7:0] HDR_BWR = 8'h7A;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] mosi_p;
  logic       cs_q, mosi_q, sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic [2:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic [6:0] rx_sr;
  logic [7:0] rx_byte, hdr, dat1, tx_sr, tx_hold, rd_lat, rd_val;
  logic       rd_slow, cap, byte_done;

  logic [7:0] priv [NBANK][NPRIV];
  logic [7:0] shr  [NSH];
  logic [1:0] bank_sel;

  function automatic logic slow_cls(input logic [1:0] b, input logic [4:0] a);
    return (b == 2'd2 && a < SH_LO) || (b == 2'd3 && (a < 5'd6 || a == 5'd10));
  endfunction

  assign cs_q      = cs_p[1];
  assign mosi_q    = mosi_p[1];
  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign sclk_fall = ~sclk_p[1] & sclk_p[2];
  assign cs_rise   = cs_p[1] & ~cs_p[2];
  assign cs_fall   = ~cs_p[1] & cs_p[2];
  assign rx_byte   = {rx_sr, mosi_q};
  assign byte_done = ~cs_q & ~cs_fall & sclk_rise & (bit_cnt == 3'd7);
  assign bank_sel  = shr[NSH-1][1:0];
  assign miso      = tx_sr[7];

  logic [4:0] ra;
  logic [2:0] rsi;
  always_comb begin
    ra  = rx_byte[4:0];
    rsi = 3'(ra - SH_LO);
    rd_val = (ra >= SH_LO) ? shr[rsi] : priv[bank_sel][ra];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p   <= '0;
      cs_p     <= '1;
      mosi_p   <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sr    <= '0;
      hdr      <= '0;
      dat1     <= '0;
      tx_sr    <= '0;
      tx_hold  <= '0;
      rd_lat   <= '0;
      rd_slow  <= 1'b0;
      cap      <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
      cap    <= buf_re;
      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        tx_sr    <= '0;
        tx_hold  <= '0;
      end else if (cs_rise) begin
        tx_sr <= '0;
      end else if (!cs_q) begin
        if (sclk_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_q};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
            if (byte_cnt == 2'd0) begin
              hdr <= rx_byte;
              if (rx_byte[7:5] == OP_RD) begin
                rd_lat  <= rd_val;
                rd_slow <= slow_cls(bank_sel, ra);
                tx_hold <= slow_cls(bank_sel, ra) ? 8'h00 : rd_val;
              end else begin
                tx_hold <= 8'h00;
              end
            end else begin
              if (byte_cnt == 2'd1) dat1 <= rx_byte;
              tx_hold <= (byte_cnt == 2'd1 && hdr[7:5] == OP_RD && rd_slow) ? rd_lat : 8'h00;
            end
          end
        end else if (sclk_fall) begin
          tx_sr <= (bit_cnt == 3'd0) ? tx_hold : {tx_sr[6:0], 1'b0};
        end
      end
      if (cap) tx_hold <= buf_rdata;
    end
  end

  logic [4:0]       wa;
  logic [2:0]       wsi;
  logic [7:0]       cur, nv;
  logic             do_commit, do_src, wr_go, rd_go;
  logic [PTR_W-1:0] rptr, wptr, rnext, wnext;
  logic [7:0]       rhi_new, whi_new;

  always_comb begin
    wa  = hdr[4:0];
    wsi = 3'(wa - SH_LO);
    cur = (wa >= SH_LO) ? shr[wsi] : priv[bank_sel][wa];
    case (hdr[7:5])
      OP_WR:   nv = dat1;
      OP_SET:  nv = cur | dat1;
      default: nv = cur & ~dat1;
    endcase
    do_commit = cs_rise && bit_cnt == 3'd0 && byte_cnt == 2'd2 &&
                (hdr[7:5] == OP_WR ||
                 ((hdr[7:5] == OP_SET || hdr[7:5] == OP_CLR) && !slow_cls(bank_sel, wa)));
    do_src = cs_rise && bit_cnt == 3'd0 && byte_cnt == 2'd1 && hdr[7:5] == OP_RST;
    wr_go  = byte_done && byte_cnt != 2'd0 && hdr == HDR_BWR;
    rd_go  = byte_done && ((byte_cnt == 2'd0) ? (rx_byte == HDR_BRD) : (hdr == HDR_BRD));
    rptr   = {priv[0][1][HI_W-1:0], priv[0][0]};
    wptr   = {priv[0][3][HI_W-1:0], priv[0][2]};
    rnext  = (byte_cnt == 2'd0) ? rptr : rptr + PTR_W'(1);
    wnext  = wptr + PTR_W'(1);
    rhi_new = priv[0][1];
    rhi_new[HI_W-1:0] = rnext[PTR_W-1:8];
    whi_new = priv[0][3];
    whi_new[HI_W-1:0] = wnext[PTR_W-1:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        for (int a = 0; a < NPRIV; a++)
          priv[b][a] <= '0;
      for (int s = 0; s < NSH; s++) shr[s] <= '0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      buf_we    <= 1'b0;
      buf_re    <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      buf_re <= 1'b0;
      if (do_commit) begin
        if (wa >= SH_LO) shr[wsi] <= nv;
        else priv[bank_sel][wa] <= nv;
      end else if (do_src) begin
        shr[NSH-1][1:0] <= 2'b00;
      end else if (wr_go) begin
        priv[0][2] <= wnext[7:0];
        priv[0][3] <= whi_new;
        buf_we     <= 1'b1;
        buf_addr   <= wptr;
        buf_wdata  <= rx_byte;
      end else if (rd_go) begin
        priv[0][0] <= rnext[7:0];
        priv[0][1] <= rhi_new;
        buf_re     <= 1'b1;
        buf_addr   <= rnext;
      end
    end
  end
endmodule

module spi_bank_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       buf_we,
  input logic       buf_re,
  input logic [1:0] bank,
  input logic       cs_sync
);
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !miso); // R1
  AST_BANK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (bank != $past(bank)) |-> $past(cs_sync)); // R5
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> !buf_we); // R10
  AST_WE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !$past(cs_sync)); // R10
  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re |=> !buf_re); // R11
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && buf_re)); // R12
endmodule

bind spi_bank_regs spi_bank_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
  .buf_we(buf_we), .buf_re(buf_re), .bank(bank_sel), .cs_sync(cs_q)
);

// File: tb/tb_spi_bank_regs.sv
module tb_spi_bank_regs;
  localparam int HALF = 6;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, buf_we, buf_re;
  logic [12:0] buf_addr;
  logic [7:0] buf_wdata, buf_rdata;

  always #10 clk = ~clk;

  spi_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_re(buf_re),
    .buf_rdata(buf_rdata)
  );

  logic [7:0] mem [64];
  logic [12:0] wl_a [16];
  logic [7:0]  wl_d [16];
  int wn = 0, rn = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 5);

  always @(posedge clk) begin
    if (buf_re) begin
      buf_rdata <= mem[buf_addr[5:0]];
      rn = rn + 1;
    end
    if (buf_we) begin
      mem[buf_addr[5:0]] = buf_wdata;
      if (wn < 16) begin
        wl_a[wn] = buf_addr;
        wl_d[wn] = buf_wdata;
      end
      wn = wn + 1;
    end
  end

  logic [7:0] tx_b [8];
  logic [7:0] rx_b [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input int nb, input int extra);
    int tot;
    tot = nb * 8 + extra;
    for (int i = 0; i < 8; i++) rx_b[i] = 8'h00;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < tot; i++) begin
      mosi = tx_b[i / 8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      rx_b[i / 8][7 - (i % 8)] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic cmd2(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d);
    tx_b[0] = {op, a};
    tx_b[1] = d;
    frame(2, 0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    cmd2(3'b010, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input bit dly, output logic [7:0] v);
    tx_b[0] = {3'b000, a};
    tx_b[1] = 8'h00;
    tx_b[2] = 8'h00;
    frame(dly ? 3 : 2, 0);
    v = dly ? rx_b[2] : rx_b[1];
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R14 miso after reset", 32'(miso), 0);
    chk("R14 strobes after reset", {30'd0, buf_we, buf_re}, 0);
    rd(5'h1F, 0, v); chk("R14 reg 0x1F reset", v, 8'h00);
    rd(5'h00, 0, v); chk("R14 pointer reg reset", v, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    wr(5'h05, 8'hA5);
    rd(5'h05, 0, v); chk("R2 R3 readback 0x05", v, 8'hA5);
    chk("R1 header byte returns 0x00", rx_b[0], 8'h00);
    wr(5'h1A, 8'h3C);
    rd(5'h1A, 0, v); chk("R3 readback 0x1A", v, 8'h3C);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    wr(5'h1F, 8'h01);
    wr(5'h05, 8'h11);
    wr(5'h1C, 8'h77);
    rd(5'h1F, 0, v); chk("R5 bank select readback", v, 8'h01);
    wr(5'h1F, 8'h00);
    rd(5'h05, 0, v); chk("R5 bank 0 private kept", v, 8'hA5);
    rd(5'h1C, 0, v); chk("R5 shared register seen in bank 0", v, 8'h77);
    wr(5'h1F, 8'h01);
    rd(5'h05, 0, v); chk("R5 bank 1 private", v, 8'h11);
  endtask

  task automatic t_delayed;
    logic [7:0] v;
    wr(5'h1F, 8'h02);
    wr(5'h04, 8'h5A);
    rd(5'h04, 1, v);
    chk("R4 dummy byte is 0x00", rx_b[1], 8'h00);
    chk("R4 delayed data on third byte", v, 8'h5A);
    wr(5'h1F, 8'h03);
    wr(5'h06, 8'h66);
    rd(5'h06, 0, v); chk("R4 bank 3 0x06 not delayed", v, 8'h66);
    wr(5'h0A, 8'h3B);
    rd(5'h0A, 1, v); chk("R4 bank 3 0x0A delayed", v, 8'h3B);
    wr(5'h1F, 8'h02);
  endtask

  task automatic t_setclr;
    logic [7:0] v;
    cmd2(3'b100, 5'h1F, 8'h01);
    rd(5'h06, 0, v); chk("R6 set on 0x1F selects bank 3", v, 8'h66);
    cmd2(3'b101, 5'h1F, 8'h03);
    rd(5'h05, 0, v); chk("R6 clear on 0x1F selects bank 0", v, 8'hA5);
    cmd2(3'b100, 5'h05, 8'h0A);
    rd(5'h05, 0, v); chk("R6 set ORs", v, 8'hAF);
    cmd2(3'b101, 5'h05, 8'h21);
    rd(5'h05, 0, v); chk("R6 clear AND-NOTs", v, 8'h8E);
  endtask

  task automatic t_setclr_delayed;
    logic [7:0] v;
    wr(5'h1F, 8'h02);
    cmd2(3'b100, 5'h04, 8'hFF);
    rd(5'h04, 1, v); chk("R7 set ignored on delayed reg", v, 8'h5A);
    cmd2(3'b101, 5'h04, 8'hFF);
    rd(5'h04, 1, v); chk("R7 clear ignored on delayed reg", v, 8'h5A);
    wr(5'h1F, 8'h00);
  endtask

  task automatic t_src;
    logic [7:0] v;
    wr(5'h1F, 8'hC3);
    tx_b[0] = 8'hFF;
    frame(1, 0);
    rd(5'h1F, 0, v); chk("R8 one-byte reset clears bank bits only", v, 8'hC0);
    wr(5'h1F, 8'h03);
    tx_b[0] = 8'hE0; tx_b[1] = 8'h00;
    frame(2, 0);
    rd(5'h1F, 0, v); chk("R8 two-byte reset frame ignored", v, 8'h03);
    wr(5'h1F, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    tx_b[0] = 8'h45; frame(1, 0);
    rd(5'h05, 0, v); chk("R9 one-byte write ignored", v, 8'h8E);
    tx_b[0] = 8'h45; tx_b[1] = 8'h12; tx_b[2] = 8'h34; frame(3, 0);
    rd(5'h05, 0, v); chk("R9 three-byte write ignored", v, 8'h8E);
    tx_b[0] = 8'h45; tx_b[1] = 8'h12; tx_b[2] = 8'h00; frame(2, 3);
    rd(5'h05, 0, v); chk("R9 partial trailing byte ignored", v, 8'h8E);
    cmd2(3'b110, 5'h05, 8'h12);
    rd(5'h05, 0, v); chk("R9 opcode 110 ignored", v, 8'h8E);
    cmd2(3'b110, 5'h1F, 8'h03);
    rd(5'h1F, 0, v); chk("R9 opcode 110 on 0x1F ignored", v, 8'h00);
  endtask

  task automatic t_bufwr;
    logic [7:0] v;
    int w0;
    wr(5'h02, 8'h10);
    wr(5'h03, 8'h00);
    w0 = wn;
    tx_b[0] = 8'h7A; tx_b[1] = 8'hD1; tx_b[2] = 8'hD2; tx_b[3] = 8'hD3;
    frame(4, 0);
    chk("R10 write strobe count", 32'(wn - w0), 3);
    for (int k = 0; k < 3; k++) begin
      chk("R10 write address", 32'(wl_a[w0 + k]), 32'(13'h10 + 13'(k)));
      chk("R10 write data", 32'(wl_d[w0 + k]), 32'(8'hD1 + 8'(k)));
    end
    rd(5'h02, 0, v); chk("R10 write pointer advanced", v, 8'h13);
  endtask

  task automatic t_bufrd;
    logic [7:0] v;
    wr(5'h00, 8'h20);
    wr(5'h01, 8'h00);
    tx_b[0] = 8'h3A; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'h00;
    frame(4, 0);
    for (int k = 1; k <= 3; k++)
      chk("R11 read data byte", rx_b[k], 32'(8'((32 + k - 1) * 3 + 5)));
    rd(5'h00, 0, v); chk("R11 read pointer advanced", v, 8'h23);
  endtask

  task automatic t_badbuf;
    int w0, r0;
    w0 = wn; r0 = rn;
    tx_b[0] = 8'h3B; tx_b[1] = 8'h99; tx_b[2] = 8'h98; frame(3, 0);
    tx_b[0] = 8'h7B; tx_b[1] = 8'h55; tx_b[2] = 8'h56; frame(3, 0);
    chk("R12 no write strobes", 32'(wn - w0), 0);
    chk("R12 no read strobes", 32'(rn - r0), 0);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    int w0;
    wr(5'h02, 8'hFF);
    wr(5'h03, 8'h1F);
    w0 = wn;
    tx_b[0] = 8'h7A; tx_b[1] = 8'hE1; tx_b[2] = 8'hE2;
    frame(3, 0);
    chk("R13 address before wrap", 32'(wl_a[w0]), 32'(13'h1FFF));
    chk("R13 address after wrap", 32'(wl_a[w0 + 1]), 0);
    rd(5'h02, 0, v); chk("R13 pointer low after wrap", v, 8'h01);
    rd(5'h03, 0, v); chk("R13 pointer high after wrap", v, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write_read;
    t_banks;
    t_delayed;
    t_setclr;
    t_setclr_delayed;
    t_src;
    t_abort;
    t_bufwr;
    t_bufrd;
    t_badbuf;
    t_wrap;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule